// File: doc/BRIEF.md
# Receive Carrier Detector with Pulse Qualification

This block decides whether a real packet is arriving on a receive line that has already been sliced into a single bit. A 1 on the line means the analog input is past the negative threshold. The block runs on a fast sampling clock. The line first passes through a two-flop synchronizer.

After the synchronizer, two separate widths are applied. A glitch filter produces a cleaned copy of the line that changes level only after the new level has been held for `GLITCH_CYC` samples. A qualifier raises the internal carrier flag once the line has been high for `QUAL_CYC` consecutive samples. When the carrier rises, the receive-enable output rises with it, and a one-cycle acquisition-start pulse tells the clock-recovery logic to begin.

The carrier ends once the cleaned line has stayed low for `HOLD_CYC` samples. Any cleaned activity during that window restarts the count. Receive-enable does not fall with the carrier. It is turned off only on a cycle where the recovered-clock strobe (`tick_i`, issued at the 3/4 point of each bit cell) finds the carrier already low. All pins are plain control signals with no handshake.

Top module: `carrier_sense`

## Requirements
- R1: While `rst_n` is low, `carrier_o`, `rx_en_o` and `acq_start_o` are 0, including when reset is applied in the middle of a packet.
- R2: A high pulse on `line_i` lasting fewer than `QUAL_CYC` clock cycles never raises `carrier_o` or `acq_start_o`. This covers pulses shorter than `GLITCH_CYC` and pulses between the two widths.
- R3: When `line_i` is taken high and held, `carrier_o` first reads 1 after the (`QUAL_CYC`+2)th rising edge, counting the first edge that samples the high level as edge 1. With the defaults this is edge 11.
- R4: `acq_start_o` is high for exactly one cycle per qualified packet, in the same cycle that `carrier_o` rises.
- R5: `rx_en_o` rises in the same cycle as `carrier_o`, and it is high whenever `carrier_o` is high.
- R6: When `line_i` falls and then stays low, `carrier_o` first reads 0 after the (`GLITCH_CYC`+`HOLD_CYC`+2)th rising edge, counting the first edge that samples the low level as edge 1. With the defaults this is edge 38.
- R7: A high pulse shorter than `GLITCH_CYC` cycles during the end-of-carrier window does not change when the carrier falls.
- R8: A high pulse of at least `GLITCH_CYC` cycles during the end-of-carrier window restarts the hold-off, so the carrier falls later than the R6 time.
- R9: `rx_en_o` falls only at a rising edge where `tick_i` is 1 and the carrier is already low. Until that edge it stays high after the carrier ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sliced receive line; 1 = negative excursion |
| tick_i | input | 1 | Recovered-clock strobe at 3/4 bit time, one cycle wide |
| carrier_o | output | 1 | Internal carrier flag |
| rx_en_o | output | 1 | Receive enable |
| acq_start_o | output | 1 | One-cycle pulse that starts clock acquisition |

## Verification
The assertions assume three things about the inputs. `tick_i` is a single-cycle strobe. `line_i` may change at any time, because it is asynchronous. Reset is released while the line is idle. The stimulus drives `line_i` and `tick_i` only on falling clock edges. It issues the strobe once every 40 cycles from a free-running counter, and it releases reset only with the line held low. Pulse widths are chosen to fall on either side of `GLITCH_CYC` and `QUAL_CYC`, and glitches are placed inside the hold-off window so that the restart rule is exercised from both sides.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_ACTIVE = 2'd1,
    CS_DRAIN  = 2'd2
  } cs_state_e;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cs_deglitch.sv
module cs_deglitch #(
  parameter int unsigned GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(GLITCH_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
      cnt <= '0;
    end else if (d_i == q_o) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      q_o <= d_i;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: the cleaned level only ever moves toward the level last seen at its input
  a_r7_follow_input: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o != $past(q_o)) |-> ($past(d_i) == q_o));
endmodule

// File: rtl/cs_run_qual.sv
module cs_run_qual #(
  parameter int unsigned QUAL_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic hit_o
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] RUN_LAST = QW'(QUAL_CYC - 1);

  logic [QW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run <= '0;
    else if (!d_i)           run <= '0;
    else if (run != RUN_LAST) run <= run + 1'b1;
  end

  assign hit_o = d_i && (run == RUN_LAST);
endmodule

// File: rtl/carrier_sense.sv
module carrier_sense
  import cs_pkg::*;
#(
  parameter int unsigned GLITCH_CYC = 4,
  parameter int unsigned QUAL_CYC   = 9,
  parameter int unsigned HOLD_CYC   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic tick_i,
  output logic carrier_o,
  output logic rx_en_o,
  output logic acq_start_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  logic          line_s;
  logic          line_f;
  logic          qual_hit;
  logic [HW-1:0] hold_cnt;
  logic          hold_done;
  cs_state_e     state, state_nx;
  logic          acq_q;

  cs_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
  );

  cs_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_deglitch (
    .clk(clk), .rst_n(rst_n), .d_i(line_s), .q_o(line_f)
  );

  cs_run_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .d_i(line_s), .hit_o(qual_hit)
  );

  // end-of-carrier hold-off: counts quiet cleaned samples while active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           hold_cnt <= '0;
    else if (state != CS_ACTIVE || line_f) hold_cnt <= '0;
    else if (!hold_done)                  hold_cnt <= hold_cnt + 1'b1;
  end

  assign hold_done = !line_f && (hold_cnt == HOLD_LAST);

  always_comb begin
    state_nx = state;
    unique case (state)
      CS_IDLE:   if (qual_hit) state_nx = CS_ACTIVE;
      CS_ACTIVE: if (hold_done) state_nx = CS_DRAIN;
      CS_DRAIN: begin
        if (qual_hit)    state_nx = CS_ACTIVE;
        else if (tick_i) state_nx = CS_IDLE;
      end
      default:   state_nx = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CS_IDLE;
      acq_q <= 1'b0;
    end else begin
      state <= state_nx;
      acq_q <= (state != CS_ACTIVE) && (state_nx == CS_ACTIVE);
    end
  end

  assign carrier_o   = (state == CS_ACTIVE);
  assign rx_en_o     = (state != CS_IDLE);
  assign acq_start_o = acq_q;

  // R3: a carrier rise is preceded by a high synchronized line
  a_r3_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_o) |-> $past(line_s));
  // R4: the start pulse lasts one cycle and marks a carrier rise
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start_o |=> !acq_start_o);
  a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start_o |-> (carrier_o && !$past(carrier_o)));
  // R5: enable covers the carrier
  a_r5_enable_covers: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_o |-> rx_en_o);
  // R6: carrier cannot end while cleaned activity is present
  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_o && line_f) |=> carrier_o);
  // R9: enable only turns off on a strobe with carrier already low
  a_r9_drop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en_o) |-> ($past(tick_i) && !$past(carrier_o)));
endmodule

// File: tb/test_carrier_sense.sv
`timescale 1ns/1ps
module test_carrier_sense;
  localparam int G = 4;
  localparam int Q = 9;
  localparam int H = 32;
  localparam int RISE_EDGES = Q + 2;
  localparam int FALL_EDGES = G + H + 2;
  localparam int NV = 7;
  // {pulse width in cycles, carrier expected}
  localparam int VEC [NV][2] = '{
    '{1, 0}, '{3, 0}, '{4, 0}, '{8, 0}, '{9, 1}, '{10, 1}, '{20, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_i = 1'b0;
  logic tick_i = 1'b0;
  logic carrier_o, rx_en_o, acq_start_o;

  int checks = 0;
  int errors = 0;
  int acq_cnt = 0;
  bit carrier_seen = 1'b0;
  bit prev_rx = 1'b0;
  bit prev_acq = 1'b0;
  bit tick_q = 1'b0;
  int tick_ctr = 0;

  carrier_sense #(.GLITCH_CYC(G), .QUAL_CYC(Q), .HOLD_CYC(H)) i_carrier_sense (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .tick_i(tick_i),
    .carrier_o(carrier_o), .rx_en_o(rx_en_o), .acq_start_o(acq_start_o)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick_ctr <= (tick_ctr == 39) ? 0 : tick_ctr + 1;
    tick_i   <= (tick_ctr == 39);
  end

  always @(posedge clk) tick_q <= tick_i;

  // monitors for R4 and R9
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_rx <= 1'b0;
      prev_acq <= 1'b0;
    end else begin
      if (acq_start_o) acq_cnt <= acq_cnt + 1;
      if (carrier_o) carrier_seen <= 1'b1;
      if (prev_acq && acq_start_o) check(1'b0, "R4 pulse width", 2, 1);
      if (prev_rx && !rx_en_o) check(tick_q == 1'b1, "R9 drop on tick", tick_q, 1);
      prev_rx <= rx_en_o;
      prev_acq <= acq_start_o;
    end
  end

  task automatic wait_idle();
    while (rx_en_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic count_until(input bit level, output int n);
    n = 0;
    while (carrier_o != level && n < 500) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check({carrier_o, rx_en_o, acq_start_o} == 3'b000, "R1 reset state",
          {carrier_o, rx_en_o, acq_start_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk: R2, R4, R5
    for (int v = 0; v < NV; v++) begin
      wait_idle();
      acq_cnt = 0;
      carrier_seen = 1'b0;
      line_i = 1'b1;
      repeat (VEC[v][0]) @(negedge clk);
      line_i = 1'b0;
      repeat (120) @(negedge clk);
      check(acq_cnt == VEC[v][1], "R2/R4 start pulses per width", acq_cnt, VEC[v][1]);
      check(carrier_seen == VEC[v][1], "R2 carrier for width", carrier_seen, VEC[v][1]);
      check(rx_en_o == 1'b0, "R9 enable released", rx_en_o, 0);
    end

    // R3 and R5: rise timing
    wait_idle();
    line_i = 1'b1;
    count_until(1'b1, n);
    check(n == RISE_EDGES, "R3 rise edge", n, RISE_EDGES);
    check(rx_en_o == 1'b1, "R5 enable with carrier", rx_en_o, 1);
    check(acq_start_o == 1'b1, "R4 pulse with rise", acq_start_o, 1);
    repeat (10) @(negedge clk);

    // R6: fall timing
    line_i = 1'b0;
    count_until(1'b0, n);
    check(n == FALL_EDGES, "R6 fall edge", n, FALL_EDGES);
    check(rx_en_o == 1'b1 || tick_q, "R9 enable held past carrier", rx_en_o, 1);

    // R7: short glitch inside the hold-off
    wait_idle();
    line_i = 1'b1;
    repeat (20) @(negedge clk);
    line_i = 1'b0;
    fork
      begin
        repeat (10) @(negedge clk);
        line_i = 1'b1;
        repeat (G - 1) @(negedge clk);
        line_i = 1'b0;
      end
      count_until(1'b0, n);
    join
    check(n == FALL_EDGES, "R7 short glitch ignored", n, FALL_EDGES);

    // R8: long pulse inside the hold-off restarts it
    wait_idle();
    acq_cnt = 0;
    line_i = 1'b1;
    repeat (20) @(negedge clk);
    line_i = 1'b0;
    fork
      begin
        repeat (10) @(negedge clk);
        line_i = 1'b1;
        repeat (G + 2) @(negedge clk);
        line_i = 1'b0;
      end
      count_until(1'b0, n);
    join
    check(n > FALL_EDGES && n < 500, "R8 hold-off restarted", n, FALL_EDGES + 1);
    wait_idle();
    check(acq_cnt == 1, "R4 once per packet", acq_cnt, 1);

    // R1: reset in the middle of a packet
    line_i = 1'b1;
    repeat (15) @(negedge clk);
    check(carrier_o == 1'b1, "R3 carrier before reset", carrier_o, 1);
    rst_n = 1'b0;
    #1;
    check({carrier_o, rx_en_o, acq_start_o} == 3'b000, "R1 mid-packet reset",
          {carrier_o, rx_en_o, acq_start_o}, 0);
    line_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_en_o == 1'b0, "R1 idle after reset", rx_en_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule